// File: doc/BRIEF.md
# Parallel ATA PIO Strobe Sequencer

This block turns single host requests into read or write strobe cycles on a legacy parallel ATA register interface. A request carries a direction, a 10-bit I/O address and a target drive (0 or 1). The block decodes the address against the command-register window and the alternate-status/control register of two channels. It then raises the matching strobe, waits a programmed number of clocks before looking at the device ready line, and enforces a recovery gap once the strobe drops. Finally it reports completion with a one-cycle done pulse.

Timing comes from a 16-bit configuration word plus a 4-bit alternate timing word for drive 1. Each drive can select programmed ("fast") timing or fixed compatible timing. Programmed timing only ever applies to the 16-bit data register at offset 0 of a command window. Every other register access, and any access to a drive flagged as DMA-only-fast, runs compatible timing: 5 clocks to the sample and 4 clocks of recovery.

Top module: `ide_pio_timer`

## Requirements
- R1: Address decode. `cfg_word[11]` enables the primary channel, which owns 0x1F0–0x1F7 and 0x3F6. `cfg_word[12]` enables the secondary channel, which owns 0x170–0x177 and 0x376. A decoded request drives `ide_chan` (0 = primary, 1 = secondary), `ide_ctrl` (1 for the control register) and `ide_addr` = address bits [2:0] throughout the strobe. Any other address, or an address on a disabled channel, raises no strobe: `done` and `miss` are both high in the cycle after the request.
- R2: For programmed timing, `cfg_word[1:0]` sets the strobe length up to the ready sample: 00 = 5 clocks, 01 = 4 clocks, 10 = 3 clocks, 11 = 5 clocks.
- R3: For programmed timing, `cfg_word[3:2]` sets the recovery length from the final ready sample to `done`: 00 = 4 clocks, 01 = 3, 10 = 2, 11 = 1.
- R4: When a drive's fast bit is 0, every access to that drive uses compatible timing (5 / 4). The fast bits are `cfg_word[4]` for drive 0 and `cfg_word[7]` for drive 1.
- R5: When a drive's DMA-only bit is 1, its PIO accesses use compatible timing even with the fast bit set. The DMA-only bits are `cfg_word[6]` for drive 0 and `cfg_word[9]` for drive 1.
- R6: Programmed timing is used only for the data register (command window, offset 0). All other registers use compatible timing.
- R7: When `cfg_word[10]` is 1, drive 1 takes its sample and recovery codes from `drv1_word` ([1:0] sample, [3:2] recovery, same encodings as R2 and R3). When `cfg_word[10]` is 0, drive 1 uses the fields in `cfg_word`. Drive 0 always uses `cfg_word`.
- R8: When a drive's ready enable is 1, a strobe whose ready sample sees `ide_ready` low stays high, and the line is resampled every clock until it is seen high. When the ready enable is 0, `ide_ready` is ignored. The ready enables are `cfg_word[5]` for drive 0 and `cfg_word[8]` for drive 1.
- R9: A read captures `ide_rdata` at the clock edge of the final ready sample and holds it on `rdata`. A write presents `req_wdata` on `ide_wdata` for the whole strobe.
- R10: `done` is a single-cycle pulse. A request that arrives while a cycle is in progress, or in the cycle `done` is high, is ignored.
- R11: During and after reset there is no strobe, no `done` and no `miss`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 16 | Timing and decode configuration |
| drv1_word | input | 4 | Alternate drive-1 timing codes |
| req | input | 1 | Request pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | I/O address |
| req_drive | input | 1 | Target drive |
| req_wdata | input | 16 | Write data |
| done | output | 1 | Completion pulse |
| miss | output | 1 | With done: address not decoded |
| rdata | output | 16 | Captured read data |
| ide_rd | output | 1 | Read strobe (active high) |
| ide_wr | output | 1 | Write strobe (active high) |
| ide_chan | output | 1 | Selected channel |
| ide_ctrl | output | 1 | Control register selected |
| ide_addr | output | 3 | Register offset |
| ide_wdata | output | 16 | Data driven to device |
| ide_rdata | input | 16 | Data from device |
| ide_ready | input | 1 | Device ready line |

## Verification
A wrong countdown value or a wrong timing selection shows at the ports within one transaction: the strobe is longer or shorter than expected, or `done` comes early or late. A read that captures data on the wrong edge returns the bench's decoy value instead of the marked value. A stuck sequencer state shows either as a strobe that never drops or as a missing `done`. The bench catches both through its per-transaction cycle cap.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 10;
    localparam int CNT_W  = 4;
    localparam int NCHAN  = 2;
    localparam int OFF_W  = 3;

    localparam logic [CNT_W-1:0] COMPAT_SMP = CNT_W'(5);
    localparam logic [CNT_W-1:0] COMPAT_RCV = CNT_W'(4);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RECOVER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [1:0] rcv;
        logic [1:0] smp;
    } timing_pair_t;

    typedef struct packed {
        logic [2:0]   unused;
        logic         sec_en;
        logic         pri_en;
        logic         sep1;
        logic         dma1;
        logic         rdy1;
        logic         fast1;
        logic         dma0;
        logic         rdy0;
        logic         fast0;
        timing_pair_t main;
    } cfg_word_t;

    typedef struct packed {
        logic             hit;
        logic             chan;
        logic             ctrl;
        logic [OFF_W-1:0] reg_off;
        logic             is_data;
    } decode_t;

    typedef struct packed {
        logic [CNT_W-1:0] smp_clks;
        logic [CNT_W-1:0] rcv_clks;
        logic             rdy_en;
    } timing_t;

    function automatic logic [CNT_W-1:0] smp_clocks(input logic [1:0] code);
        case (code)
            2'b01:   return CNT_W'(4);
            2'b10:   return CNT_W'(3);
            default: return CNT_W'(5);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] rcv_clocks(input logic [1:0] code);
        return CNT_W'(3'd4 - {1'b0, code});
    endfunction

endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
    import ide_pio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [NCHAN-1:0]  chan_en,
    output decode_t           dec
);
    logic [NCHAN-1:0] cmd_hit;
    logic [NCHAN-1:0] ctl_hit;

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        localparam logic [ADDR_W-1:0] CMD_BASE = (c == 0) ? 10'h1F0 : 10'h170;
        localparam logic [ADDR_W-1:0] CTL_ADDR = (c == 0) ? 10'h3F6 : 10'h376;
        assign cmd_hit[c] = chan_en[c] && (addr[ADDR_W-1:OFF_W] == CMD_BASE[ADDR_W-1:OFF_W]);
        assign ctl_hit[c] = chan_en[c] && (addr == CTL_ADDR);
    end

    always_comb begin
        dec.hit     = |(cmd_hit | ctl_hit);
        dec.chan    = cmd_hit[1] | ctl_hit[1];
        dec.ctrl    = |ctl_hit;
        dec.reg_off = addr[OFF_W-1:0];
        dec.is_data = (|cmd_hit) && (addr[OFF_W-1:0] == '0);
    end
endmodule

// File: rtl/ide_timing_select.sv
module ide_timing_select
    import ide_pio_pkg::*;
(
    input  cfg_word_t    cfg,
    input  timing_pair_t alt,
    input  logic         drive,
    input  logic         is_data,
    output timing_t      tim
);
    logic         fast;
    logic         dma_only;
    logic         use_prog;
    timing_pair_t src;

    always_comb begin
        fast     = drive ? cfg.fast1 : cfg.fast0;
        dma_only = drive ? cfg.dma1  : cfg.dma0;
        use_prog = is_data && fast && !dma_only;
        src      = (drive && cfg.sep1) ? alt : cfg.main;

        tim.rdy_en   = drive ? cfg.rdy1 : cfg.rdy0;
        tim.smp_clks = use_prog ? smp_clocks(src.smp) : COMPAT_SMP;
        tim.rcv_clks = use_prog ? rcv_clocks(src.rcv) : COMPAT_RCV;
    end

    always_comb begin
        // R2
        smp_range_chk: assert (tim.smp_clks >= CNT_W'(3) && tim.smp_clks <= CNT_W'(5));
        // R3
        rcv_range_chk: assert (tim.rcv_clks >= CNT_W'(1) && tim.rcv_clks <= CNT_W'(4));
    end
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
    import ide_pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_write,
    input  decode_t           dec,
    input  timing_t           tim,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ide_rdata,
    input  logic              ide_ready,
    output logic              done,
    output logic              miss,
    output logic [DATA_W-1:0] rdata,
    output logic              ide_rd,
    output logic              ide_wr,
    output logic              ide_chan,
    output logic              ide_ctrl,
    output logic [OFF_W-1:0]  ide_addr,
    output logic [DATA_W-1:0] ide_wdata
);
    seq_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rcv_q;
    logic             wr_q;
    logic             rdy_en_q;
    logic             strobe;

    assign strobe = (st == ST_STROBE);
    assign ide_rd = strobe && !wr_q;
    assign ide_wr = strobe && wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            rcv_q     <= '0;
            wr_q      <= 1'b0;
            rdy_en_q  <= 1'b0;
            done      <= 1'b0;
            miss      <= 1'b0;
            rdata     <= '0;
            ide_chan  <= 1'b0;
            ide_ctrl  <= 1'b0;
            ide_addr  <= '0;
            ide_wdata <= '0;
        end else begin
            done <= 1'b0;
            miss <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req && !done) begin
                        if (dec.hit) begin
                            st        <= ST_STROBE;
                            cnt       <= tim.smp_clks - CNT_W'(1);
                            rcv_q     <= tim.rcv_clks;
                            rdy_en_q  <= tim.rdy_en;
                            wr_q      <= req_write;
                            ide_chan  <= dec.chan;
                            ide_ctrl  <= dec.ctrl;
                            ide_addr  <= dec.reg_off;
                            ide_wdata <= req_wdata;
                        end else begin
                            done <= 1'b1;
                            miss <= 1'b1;
                        end
                    end
                end
                ST_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CNT_W'(1);
                    end else if (!rdy_en_q || ide_ready) begin
                        if (!wr_q) rdata <= ide_rdata;
                        cnt <= rcv_q - CNT_W'(1);
                        st  <= ST_RECOVER;
                    end
                end
                ST_RECOVER: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CNT_W'(1);
                    end else begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && $past(strobe)) |-> ($stable(ide_addr) && $stable(ide_chan) && $stable(ide_ctrl)));

    // R8
    ready_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe) |-> (!rdy_en_q || $past(ide_ready)));

    // R3
    recovery_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe) |-> !done);
endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
    import ide_pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cfg_word,
    input  logic [3:0]        drv1_word,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_drive,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic              miss,
    output logic [DATA_W-1:0] rdata,
    output logic              ide_rd,
    output logic              ide_wr,
    output logic              ide_chan,
    output logic              ide_ctrl,
    output logic [OFF_W-1:0]  ide_addr,
    output logic [DATA_W-1:0] ide_wdata,
    input  logic [DATA_W-1:0] ide_rdata,
    input  logic              ide_ready
);
    cfg_word_t    cfg;
    timing_pair_t alt;
    decode_t      dec;
    timing_t      tim;

    assign cfg = cfg_word;
    assign alt = drv1_word;

    ide_addr_decode u_dec (
        .addr    (req_addr),
        .chan_en ({cfg.sec_en, cfg.pri_en}),
        .dec     (dec)
    );

    ide_timing_select u_sel (
        .cfg     (cfg),
        .alt     (alt),
        .drive   (req_drive),
        .is_data (dec.is_data),
        .tim     (tim)
    );

    ide_pio_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_write (req_write),
        .dec       (dec),
        .tim       (tim),
        .req_wdata (req_wdata),
        .ide_rdata (ide_rdata),
        .ide_ready (ide_ready),
        .done      (done),
        .miss      (miss),
        .rdata     (rdata),
        .ide_rd    (ide_rd),
        .ide_wr    (ide_wr),
        .ide_chan  (ide_chan),
        .ide_ctrl  (ide_ctrl),
        .ide_addr  (ide_addr),
        .ide_wdata (ide_wdata)
    );
endmodule

// File: tb/ide_pio_timer_test.sv
`timescale 1ns/1ps
module ide_pio_timer_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cfg_word;
    logic [3:0]  drv1_word;
    logic        req, req_write, req_drive;
    logic [9:0]  req_addr;
    logic [15:0] req_wdata;
    logic        done, miss;
    logic [15:0] rdata;
    logic        ide_rd, ide_wr, ide_chan, ide_ctrl;
    logic [2:0]  ide_addr;
    logic [15:0] ide_wdata, ide_rdata;
    logic        ide_ready;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ide_pio_timer uut (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .drv1_word(drv1_word),
        .req(req), .req_write(req_write), .req_addr(req_addr), .req_drive(req_drive),
        .req_wdata(req_wdata), .done(done), .miss(miss), .rdata(rdata),
        .ide_rd(ide_rd), .ide_wr(ide_wr), .ide_chan(ide_chan), .ide_ctrl(ide_ctrl),
        .ide_addr(ide_addr), .ide_wdata(ide_wdata), .ide_rdata(ide_rdata),
        .ide_ready(ide_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    function automatic void model(input logic [9:0] a, input logic drv,
                                  output bit hit, output bit chan, output bit ctrl,
                                  output int s, output int r, output bit ren);
        bit p_cmd, s_cmd, p_ctl, s_ctl, data, fast, dma, prog;
        logic [3:0] src;
        p_cmd = cfg_word[11] && (a[9:3] == 7'h3E);
        s_cmd = cfg_word[12] && (a[9:3] == 7'h2E);
        p_ctl = cfg_word[11] && (a == 10'h3F6);
        s_ctl = cfg_word[12] && (a == 10'h376);
        hit   = p_cmd || s_cmd || p_ctl || s_ctl;
        chan  = s_cmd || s_ctl;
        ctrl  = p_ctl || s_ctl;
        data  = (p_cmd || s_cmd) && (a[2:0] == 3'd0);
        fast  = drv ? cfg_word[7] : cfg_word[4];
        dma   = drv ? cfg_word[9] : cfg_word[6];
        ren   = drv ? cfg_word[8] : cfg_word[5];
        src   = (drv && cfg_word[10]) ? drv1_word : cfg_word[3:0];
        prog  = data && fast && !dma;
        if (prog) begin
            s = (src[1:0] == 2'b01) ? 4 : (src[1:0] == 2'b10) ? 3 : 5;
            r = 4 - int'(src[3:2]);
        end else begin
            s = 5;
            r = 4;
        end
    endfunction

    task automatic txn(input bit wr, input logic [9:0] a, input bit drv,
                       input int w, input bit poke, input string tag);
        bit hit, chan, ctrl, ren;
        int s, r, n, rec, cyc, fin, bad_strb, bad_wd;
        logic [15:0] good, wd;
        model(a, drv, hit, chan, ctrl, s, r, ren);
        fin  = ren ? s + w : s;
        good = 16'($urandom);
        wd   = 16'($urandom);
        n = 0; rec = 0; cyc = 0; bad_strb = 0; bad_wd = 0;
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a; req_drive = drv; req_wdata = wd;
        ide_ready = 1'b0; ide_rdata = ~good;
        @(negedge clk);
        req = 1'b0;
        while (!done && cyc < 60) begin
            req = 1'b0;
            if (ide_rd || ide_wr) begin
                n++;
                if (ide_wr != wr || ide_rd == wr || ide_addr != a[2:0] ||
                    ide_chan != chan || ide_ctrl != ctrl) bad_strb++;
                if (wr && ide_wdata != wd) bad_wd++;
                ide_ready = (n >= s + w);
                ide_rdata = (n == fin) ? good : ~good;
                if (poke && n == 1) begin
                    req = 1'b1; req_addr = 10'h3F6; req_write = ~wr;
                end
            end else if (n > 0) begin
                rec++;
            end
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, {tag, " done seen"}, done, 1);
        if (hit) begin
            // R1 R2 R4 R5 R6 R7 R8: strobe length
            chk(n == fin, {tag, " strobe clocks"}, n, fin);
            // R3: recovery length
            chk(rec == r, {tag, " recovery clocks"}, rec, r);
            // R1: strobe kind and address outputs
            chk(bad_strb == 0, {tag, " R1 strobe/addr"}, bad_strb, 0);
            chk(miss == 1'b0, {tag, " R1 miss low"}, miss, 0);
            // R9: data
            if (wr) chk(bad_wd == 0, {tag, " R9 wdata"}, bad_wd, 0);
            else    chk(rdata == good, {tag, " R9 rdata"}, rdata, good);
        end else begin
            // R1: undecoded
            chk(n == 0 && cyc == 0, {tag, " R1 no strobe, immediate done"}, n + cyc, 0);
            chk(miss == 1'b1, {tag, " R1 miss high"}, miss, 1);
        end
        @(negedge clk);
        // R10: single-cycle done
        chk(done == 1'b0, {tag, " R10 done single"}, done, 0);
        if (poke) begin
            repeat (3) begin
                @(negedge clk);
                // R10: request during busy ignored
                chk(!ide_rd && !ide_wr && !done, {tag, " R10 busy req ignored"},
                    int'(ide_rd | ide_wr | done), 0);
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [9:0] a;
        void'($urandom(32'd4242));
        rst = 1'b1; req = 1'b0; req_write = 1'b0; req_addr = '0; req_drive = 1'b0;
        req_wdata = '0; ide_rdata = '0; ide_ready = 1'b0;
        cfg_word = '0; drv1_word = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!ide_rd && !ide_wr && !done && !miss, "R11 reset outputs",
            int'(ide_rd | ide_wr | done | miss), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!ide_rd && !ide_wr && !done && !miss, "R11 after reset",
            int'(ide_rd | ide_wr | done | miss), 0);

        // R4: compatible timing, both channels enabled, no fast bits
        cfg_word = 16'h1800;
        txn(0, 10'h1F0, 0, 0, 0, "R4 compat rd");
        txn(1, 10'h170, 1, 0, 0, "R4 compat wr sec");
        // R2 R3: each code on drive 0 data port
        for (int k = 0; k < 4; k++) begin
            cfg_word = 16'h1810 | 16'(k) | 16'(k << 2);
            txn(0, 10'h1F0, 0, 0, 0, "R2 R3 code sweep");
        end
        // R5: DMA-only fast falls back
        cfg_word = 16'h1850 | 16'h000A;
        txn(0, 10'h1F0, 0, 0, 0, "R5 dma-only");
        // R6: non-data register compatible
        cfg_word = 16'h181A;
        txn(0, 10'h1F3, 0, 0, 0, "R6 cmd reg");
        txn(1, 10'h3F6, 0, 0, 0, "R6 ctrl reg");
        // R7: separate drive-1 word
        cfg_word = 16'h1C80; drv1_word = 4'b1110;
        txn(0, 10'h170, 1, 0, 0, "R7 alt word");
        cfg_word = 16'h1880;
        txn(0, 10'h170, 1, 0, 0, "R7 main word");
        // R8: ready wait and ready disabled
        cfg_word = 16'h1830;
        txn(0, 10'h1F0, 0, 3, 0, "R8 ready wait");
        cfg_word = 16'h1810;
        txn(0, 10'h1F0, 0, 3, 0, "R8 ready ignored");
        // R1: disabled channel and out-of-range
        cfg_word = 16'h0800;
        txn(0, 10'h170, 0, 0, 0, "R1 disabled sec");
        txn(0, 10'h3F7, 0, 0, 0, "R1 outside");
        // R10: request while busy
        cfg_word = 16'h1800;
        txn(1, 10'h1F1, 0, 0, 1, "R10 poke");

        for (int i = 0; i < 150; i++) begin
            if (i % 8 == 0) begin
                cfg_word  = 16'($urandom);
                drv1_word = 4'($urandom);
            end
            case ($urandom % 6)
                0: a = 10'h1F0;
                1: a = 10'h170;
                2: a = (($urandom % 2) != 0 ? 10'h1F0 : 10'h170) | 10'(1 + $urandom % 7);
                3: a = (($urandom % 2) != 0) ? 10'h3F6 : 10'h376;
                4: a = 10'($urandom);
                default: a = 10'h3F7;
            endcase
            txn(bit'($urandom % 2), a, bit'($urandom % 2), int'($urandom % 4), 0, "rand R1 R2 R3 R7 R8");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule